// File: doc/BRIEF.md
# USB Device Address and Bus-Status Unit

This block holds the small set of configuration and status registers that sit between an embedded CPU and a USB serial interface engine. The CPU programs a 7-bit device address together with an enable flag, and chooses an endpoint layout (size and count). The unit compares every decoded token from the engine against that configuration and raises a match flag only when the engine should answer.

It also keeps a sticky flag that records any non-idle activity on the upstream port. The engine can set this flag and software can only clear it. The live levels of the two upstream data lines are shown in the same status register. Whenever the engine pushes bytes into an endpoint FIFO over the shared internal bus, the unit holds the CPU off that bus for a fixed number of cycles per byte.

Top module: `usbdev_cfg_unit`

## Requirements
- R1: After reset the device-address register (select 0) reads 0x00, the status/control register (select 1) reads 0x00 with both data lines low, ep_size and ep_mode are 0, and cpu_stall is 0.
- R2: A CPU write with cpu_sel=0 loads all 8 bits of the device-address register: bits [6:0] are the address and bit 7 is the enable. Reads return the stored value.
- R3: addr_match is never asserted while the enable bit (bit 7 of the device-address register) is 0.
- R4: addr_match is asserted only while tok_valid is 1 and tok_addr equals bits [6:0] of the device-address register. Address zero matches when enabled.
- R5: addr_match also requires tok_ep to be below the endpoint count: 3 when ep_mode is 0, and 5 when ep_mode is 1.
- R6: In the status/control register (cpu_sel=1), bit 7 (endpoint size) and bit 6 (endpoint mode) can be read and written. They drive ep_size and ep_mode.
- R7: A one-cycle pulse on bus_evt sets the bus-activity flag, bit 3 of the status/control register, from the next cycle on. The flag then stays set.
- R8: A status/control write with bit 3 = 0 clears the bus-activity flag. A write with bit 3 = 1 leaves it unchanged.
- R9: If bus_evt and a clearing write fall in the same cycle, the flag ends up set.
- R10: Status/control bit 5 reads the live dp_pin level and bit 4 reads the live dm_pin level (1 = high). Bits 2:0 always read 0, and writes to them have no effect.
- R11: Each cycle with fifo_wr high adds three cycles of cpu_stall, starting in the next cycle. N consecutive byte writes give exactly 3N consecutive stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | Register select: 0 device address, 1 status/control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| tok_valid | input | 1 | Engine has a decoded token this cycle |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| bus_evt | input | 1 | Non-idle event seen on upstream port |
| dp_pin | input | 1 | Upstream D+ level |
| dm_pin | input | 1 | Upstream D- level |
| fifo_wr | input | 1 | Engine writes one byte into an endpoint FIFO |
| addr_match | output | 1 | Token is for this device and a valid endpoint |
| ep_size | output | 1 | Endpoint size selection |
| ep_mode | output | 1 | Endpoint count selection |
| cpu_stall | output | 1 | CPU held off the shared bus |

## Verification
The assertions check on every cycle that a bus event always leaves the activity flag set, that a preserving write never drops it, that a clearing write without a concurrent event always drops it, that disabling the address stops matching, and that every byte write starts a stall without the stall counter running past its ceiling. Only the bench scenarios can show the exact stall length for a burst, the endpoint boundary in each mode, the winner when a set and a clear collide, and the values that read back through the register port.

// File: rtl/usbdev_cfg_pkg.sv
package usbdev_cfg_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned SC_ACT_BIT  = 3;
  localparam int unsigned SC_DM_BIT   = 4;
  localparam int unsigned SC_DP_BIT   = 5;
  localparam int unsigned SC_MODE_BIT = 6;
  localparam int unsigned SC_SIZE_BIT = 7;

  typedef enum logic {
    SEL_DEVADDR = 1'b0,
    SEL_STATCTL = 1'b1
  } reg_sel_e;

  // Endpoint count chosen by the mode bit.
  function automatic int unsigned ep_limit(input logic mode,
                                           input int unsigned few,
                                           input int unsigned many);
    return mode ? many : few;
  endfunction

  // Stall counter step: drain one per cycle, add per_byte per written byte, saturate at cap.
  function automatic int unsigned stall_next(input int unsigned cur,
                                             input logic wr,
                                             input int unsigned per_byte,
                                             input int unsigned cap);
    int unsigned sum;
    sum = cur - ((cur != 0) ? 1 : 0) + (wr ? per_byte : 0);
    return (sum > cap) ? cap : sum;
  endfunction
endpackage

// File: rtl/usbdev_addr_reg.sv
module usbdev_addr_reg
  import usbdev_cfg_pkg::*;
#(
  parameter int unsigned DEV_ADDR_W = 7,
  parameter int unsigned EP_NUM_W   = 4,
  parameter int unsigned EP_FEW     = 3,
  parameter int unsigned EP_MANY    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DEV_ADDR_W:0]   wdata,
  input  logic                  ep_mode,
  input  logic                  tok_valid,
  input  logic [DEV_ADDR_W-1:0] tok_addr,
  input  logic [EP_NUM_W-1:0]   tok_ep,
  output logic [DEV_ADDR_W:0]   rd_val,
  output logic                  addr_match
);
  localparam int unsigned LIM_W = EP_NUM_W + 1;

  logic [DEV_ADDR_W-1:0] addr_q;
  logic                  en_q;
  logic                  addr_hit;
  logic                  ep_in_range;
  logic [LIM_W-1:0]      ep_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      addr_q <= wdata[DEV_ADDR_W-1:0];
      en_q   <= wdata[DEV_ADDR_W];
    end
  end

  always_comb begin
    ep_lim      = LIM_W'(ep_limit(ep_mode, EP_FEW, EP_MANY));
    addr_hit    = tok_valid && (tok_addr == addr_q);
    ep_in_range = ({1'b0, tok_ep} < ep_lim);
    addr_match  = en_q && addr_hit && ep_in_range;
    rd_val      = {en_q, addr_q};
  end

  AST_DISABLE_STOPS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[DEV_ADDR_W]) |=> !addr_match); // R3
  AST_MATCH_ADDR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> (tok_valid && tok_addr == rd_val[DEV_ADDR_W-1:0])); // R4
endmodule

// File: rtl/usbdev_stat_ctrl.sv
module usbdev_stat_ctrl
  import usbdev_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_size,
  input  logic             wr_mode,
  input  logic             wr_act,
  input  logic             bus_evt,
  input  logic             dp_pin,
  input  logic             dm_pin,
  output logic [REG_W-1:0] rd_val,
  output logic             ep_size,
  output logic             ep_mode
);
  logic size_q, mode_q, act_q;
  logic act_set, act_clr;

  assign act_set = bus_evt;
  assign act_clr = wr_en && !wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= 1'b0;
      mode_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        size_q <= wr_size;
        mode_q <= wr_mode;
      end
      if (act_set)      act_q <= 1'b1;
      else if (act_clr) act_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val              = '0;
    rd_val[SC_SIZE_BIT] = size_q;
    rd_val[SC_MODE_BIT] = mode_q;
    rd_val[SC_DP_BIT]   = dp_pin;
    rd_val[SC_DM_BIT]   = dm_pin;
    rd_val[SC_ACT_BIT]  = act_q;
    ep_size             = size_q;
    ep_mode             = mode_q;
  end

  AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> rd_val[SC_ACT_BIT]); // R7
  AST_ACT_PRESERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_val[SC_ACT_BIT] && !(wr_en && !wr_act)) |=> rd_val[SC_ACT_BIT]); // R8
  AST_ACT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_act && !bus_evt) |=> !rd_val[SC_ACT_BIT]); // R8
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ep_mode == $past(wr_mode) && ep_size == $past(wr_size))); // R6
endmodule

// File: rtl/usbdev_bus_stall.sv
module usbdev_bus_stall
  import usbdev_cfg_pkg::*;
#(
  parameter int unsigned STALL_PER_BYTE = 3,
  parameter int unsigned MAX_BURST      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_wr,
  output logic cpu_stall
);
  localparam int unsigned CAP    = STALL_PER_BYTE * MAX_BURST;
  localparam int unsigned PEND_W = $clog2(CAP + 1);
  localparam logic [PEND_W-1:0] CAP_V = PEND_W'(CAP);

  logic [PEND_W-1:0] pending_q, pending_d;

  always_comb begin
    pending_d = PEND_W'(stall_next(int'(pending_q), fifo_wr, STALL_PER_BYTE, CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= pending_d;
  end

  assign cpu_stall = (pending_q != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q <= CAP_V); // R11
  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> cpu_stall); // R11
  AST_STALL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_wr && !cpu_stall) |=> !cpu_stall); // R11
endmodule

// File: rtl/usbdev_cfg_unit.sv
module usbdev_cfg_unit
  import usbdev_cfg_pkg::*;
#(
  parameter int unsigned DEV_ADDR_W     = 7,
  parameter int unsigned EP_NUM_W       = 4,
  parameter int unsigned EP_FEW         = 3,
  parameter int unsigned EP_MANY        = 5,
  parameter int unsigned STALL_PER_BYTE = 3,
  parameter int unsigned MAX_BURST      = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_wr,
  input  logic                  cpu_sel,
  input  logic [7:0]            cpu_wdata,
  output logic [7:0]            cpu_rdata,
  input  logic                  tok_valid,
  input  logic [DEV_ADDR_W-1:0] tok_addr,
  input  logic [EP_NUM_W-1:0]   tok_ep,
  input  logic                  bus_evt,
  input  logic                  dp_pin,
  input  logic                  dm_pin,
  input  logic                  fifo_wr,
  output logic                  addr_match,
  output logic                  ep_size,
  output logic                  ep_mode,
  output logic                  cpu_stall
);
  logic             wr_addr, wr_stat;
  logic [7:0]       addr_rd;
  logic [REG_W-1:0] stat_rd;

  assign wr_addr = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_DEVADDR);
  assign wr_stat = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_STATCTL);

  usbdev_addr_reg #(
    .DEV_ADDR_W(DEV_ADDR_W), .EP_NUM_W(EP_NUM_W),
    .EP_FEW(EP_FEW), .EP_MANY(EP_MANY)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_addr),
    .wdata(cpu_wdata[DEV_ADDR_W:0]), .ep_mode(ep_mode),
    .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .rd_val(addr_rd), .addr_match(addr_match)
  );

  usbdev_stat_ctrl u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stat),
    .wr_size(cpu_wdata[SC_SIZE_BIT]), .wr_mode(cpu_wdata[SC_MODE_BIT]),
    .wr_act(cpu_wdata[SC_ACT_BIT]), .bus_evt(bus_evt),
    .dp_pin(dp_pin), .dm_pin(dm_pin), .rd_val(stat_rd),
    .ep_size(ep_size), .ep_mode(ep_mode)
  );

  usbdev_bus_stall #(
    .STALL_PER_BYTE(STALL_PER_BYTE), .MAX_BURST(MAX_BURST)
  ) u_stall (
    .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .cpu_stall(cpu_stall)
  );

  assign cpu_rdata = (reg_sel_e'(cpu_sel) == SEL_STATCTL) ? stat_rd : addr_rd;
endmodule

// File: tb/usbdev_cfg_unit_tb_top.sv
`timescale 1ns/1ps
module usbdev_cfg_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_sel = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic tok_valid = 0;
  logic [6:0] tok_addr = 0;
  logic [3:0] tok_ep = 0;
  logic bus_evt = 0, dp_pin = 0, dm_pin = 0, fifo_wr = 0;
  logic addr_match, ep_size, ep_mode, cpu_stall;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  usbdev_cfg_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .bus_evt(bus_evt),
    .dp_pin(dp_pin), .dm_pin(dm_pin), .fifo_wr(fifo_wr),
    .addr_match(addr_match), .ep_size(ep_size), .ep_mode(ep_mode),
    .cpu_stall(cpu_stall)
  );

  // {device-address reg, mode bit, token address, token endpoint, expected match}
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {8'h85, 1'b0, 7'h05, 4'd0, 1'b1},  // R4 hit
    {8'h05, 1'b0, 7'h05, 4'd0, 1'b0},  // R3 disabled
    {8'h85, 1'b0, 7'h06, 4'd0, 1'b0},  // R4 address mismatch
    {8'h85, 1'b0, 7'h05, 4'd2, 1'b1},  // R5 last endpoint, mode 0
    {8'h85, 1'b0, 7'h05, 4'd3, 1'b0},  // R5 beyond, mode 0
    {8'h85, 1'b1, 7'h05, 4'd3, 1'b1},  // R5 mode 1
    {8'h85, 1'b1, 7'h05, 4'd4, 1'b1},  // R5 last endpoint, mode 1
    {8'h85, 1'b1, 7'h05, 4'd5, 1'b0},  // R5 beyond, mode 1
    {8'hFF, 1'b1, 7'h7F, 4'd0, 1'b1},  // R4 all-ones address
    {8'h80, 1'b0, 7'h00, 4'd1, 1'b1},  // R4 address zero enabled
    {8'h00, 1'b0, 7'h00, 4'd0, 1'b0}   // R3 address zero disabled
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic reg_rd(input logic sel, output logic [7:0] d);
    cpu_sel = sel; #1; d = cpu_rdata;
  endtask

  task automatic stall_burst(input int n);
    int hi = 0, first = -1, last = -1;
    @(negedge clk);
    fifo_wr = 1;
    for (int cyc = 1; cyc <= 3 * n + 6; cyc++) begin
      @(negedge clk);
      if (cpu_stall) begin
        hi++;
        if (first < 0) first = cyc;
        last = cyc;
      end
      if (cyc == n) fifo_wr = 0;
    end
    chk("R11 stall cycles", 8'(hi), 8'(3 * n));
    chk("R11 stall first cycle", 8'(first), 8'd1);
    chk("R11 stall last cycle", 8'(last), 8'(3 * n));
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_rd(1'b0, r); chk("R1 addr reg", r, 8'h00);
    reg_rd(1'b1, r); chk("R1 stat reg", r, 8'h00);
    chk("R1 outputs", {5'b0, ep_size, ep_mode, cpu_stall}, 8'h00);

    // R2 write/readback
    reg_wr(1'b0, 8'hA7);
    reg_rd(1'b0, r); chk("R2 readback", r, 8'hA7);

    // Vector table: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      reg_wr(1'b0, VEC[i][20:13]);
      reg_wr(1'b1, {1'b0, VEC[i][12], 6'b001000});
      @(negedge clk);
      tok_valid = 1; tok_addr = VEC[i][11:5]; tok_ep = VEC[i][4:1];
      #1;
      chk($sformatf("R3/R4/R5 vector %0d match", i), {7'b0, addr_match}, {7'b0, VEC[i][0]});
    end
    // R4 no token
    reg_wr(1'b0, 8'h85); reg_wr(1'b1, 8'h08);
    @(negedge clk); tok_valid = 0; tok_addr = 7'h05; tok_ep = 0; #1;
    chk("R4 no token", {7'b0, addr_match}, 8'h00);

    // R6 config bits
    reg_wr(1'b1, 8'hC8);
    reg_rd(1'b1, r); chk("R6 readback", r, 8'hC0);
    chk("R6 outputs", {6'b0, ep_size, ep_mode}, 8'h03);

    // R10 live pins and dead low bits
    dp_pin = 1; dm_pin = 0; reg_rd(1'b1, r); chk("R10 dp high", r, 8'hE0);
    dp_pin = 0; dm_pin = 1; reg_rd(1'b1, r); chk("R10 dm high", r, 8'hD0);
    dm_pin = 0;
    reg_wr(1'b1, 8'h0F);
    reg_rd(1'b1, r); chk("R10 low bits ignored", r, 8'h00);

    // R7 sticky set
    @(negedge clk); bus_evt = 1; @(negedge clk); bus_evt = 0;
    repeat (3) @(negedge clk);
    reg_rd(1'b1, r); chk("R7 activity set", r, 8'h08);
    // R8 preserve then clear
    reg_wr(1'b1, 8'h08);
    reg_rd(1'b1, r); chk("R8 write 1 keeps", r, 8'h08);
    reg_wr(1'b1, 8'h00);
    reg_rd(1'b1, r); chk("R8 write 0 clears", r, 8'h00);
    // R9 collision
    @(negedge clk);
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h00; bus_evt = 1;
    @(negedge clk);
    cpu_wr = 0; bus_evt = 0;
    reg_rd(1'b1, r); chk("R9 set wins", r, 8'h08);

    // R11 stall lengths
    chk("R11 idle", {7'b0, cpu_stall}, 8'h00);
    stall_burst(1);
    stall_burst(4);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule